// File: doc/BRIEF.md
# Peripheral Request Router

This block sits between the request lines of a set of peripherals and a bank of DMA channels. Each request line has its own small mapping entry. The entry holds a valid flag and the number of the channel that should service that line. Software programs the entries through a simple word-wide register port. The router then forwards every asserted request line to its channel. A channel sees the OR of all valid lines that point at it.

The entries are split across two address windows by request number. Lines 0 to 63 use the lower window at byte offset 0x100. Lines from 64 upward use the upper window at byte offset 0x1100. Inside each window, entry k sits at window base plus 4·k.

Writing zero to an entry unmaps its line, so that line reaches no channel. Routed outputs are registered and appear one clock after the request input. Read data is also registered and appears one clock after the read strobe.

Top module: `reqmap_router`

## Requirements
- R1: After reset every entry is invalid: every entry reads back as zero, and no channel output is asserted whatever the request inputs are.
- R2: The entry for request line n, for n below 64, is at byte address 0x100 + 4·n.
- R3: The entry for request line n, for n of 64 or more, is at byte address 0x1100 + 4·(n−64).
- R4: An entry reads back with the valid flag in bit 7 and the channel number in bits 4:0. All other read bits are zero, whatever was written to them.
- R5: When line n is mapped with its valid flag set to channel c, asserting line n asserts channel output c on the clock after the request is sampled.
- R6: A line whose entry has bit 7 clear forwards nothing, even when its channel field is non-zero.
- R7: Writing 0x00000000 to an entry unmaps it. That line then drives no channel, and the entry reads back as zero.
- R8: A channel output is the OR of all valid request lines mapped to that channel.
- R9: The following change no entry and read back as zero: writes or reads at an address outside both windows, at a word-unaligned address, or at a slot beyond the last implemented request line.
- R10: Rewriting an entry with a new channel number moves the line. The old channel no longer sees it, and the new channel does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is valid on the next clock |
| addr | input | 13 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| req_in | input | NUM_REQ (96) | Peripheral request lines |
| ch_req_out | output | NUM_CH (32) | Registered per-channel request outputs |

## Verification
A corrupted entry shows up at the channel outputs one clock after the affected line is raised. It shows up as a missing bit, a bit on the wrong channel, or a bit that should stay low. The bench therefore raises single lines, pairs of lines and all lines after each change to the table. It compares every output against a model of the table.

A decode fault that writes into the wrong slot shows up on the next register read, in the following cycle. Every write is therefore followed by a read of the intended slot. The aliasing case (an unaligned or out-of-range address) is checked on both the read port and the request outputs.

// File: rtl/reqmap_pkg.sv
package reqmap_pkg;

    localparam int ADDR_W     = 13;
    localparam int DATA_W     = 32;
    localparam int BANK_WORDS = 64;
    localparam int SLOT_W     = $clog2(BANK_WORDS);
    localparam int IDX_W      = SLOT_W + 1;
    localparam int CH_FIELD_W = 5;
    localparam int VALID_BIT  = 7;

    localparam logic [ADDR_W-1:0] LOW_BANK_BASE  = 13'h0100;
    localparam logic [ADDR_W-1:0] HIGH_BANK_BASE = 13'h1100;

    typedef logic [CH_FIELD_W-1:0] ch_num_t;

    typedef struct packed {
        logic    vld;
        ch_num_t ch;
    } route_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } slot_sel_t;

    function automatic logic [DATA_W-1:0] pack_route(route_t r);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VALID_BIT] = r.vld;
        w[CH_FIELD_W-1:0] = r.ch;
        return w;
    endfunction

endpackage

// File: rtl/reqmap_decode.sv
module reqmap_decode
    import reqmap_pkg::*;
#(
    parameter int NUM_REQ = 96
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_sel_t         sel
);
    localparam int WIN_LSB = SLOT_W + 2;

    logic             aligned;
    logic             in_low;
    logic             in_high;
    logic [IDX_W-1:0] raw_idx;

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        in_low  = (addr[ADDR_W-1:WIN_LSB] == LOW_BANK_BASE[ADDR_W-1:WIN_LSB]);
        in_high = (addr[ADDR_W-1:WIN_LSB] == HIGH_BANK_BASE[ADDR_W-1:WIN_LSB]);
        raw_idx = {in_high, addr[WIN_LSB-1:2]};
        sel.idx = raw_idx;
        sel.hit = aligned && (in_low || in_high) && (int'(raw_idx) < NUM_REQ);
    end

endmodule

// File: rtl/reqmap_store.sv
module reqmap_store
    import reqmap_pkg::*;
#(
    parameter int NUM_REQ = 96
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  slot_sel_t             sel,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output route_t [NUM_REQ-1:0]  table_q
);
    route_t            wr_route;
    logic              unused_wbits;
    logic [NUM_REQ-1:0] vld_vec;

    assign wr_route.vld = wdata[VALID_BIT];
    assign wr_route.ch  = wdata[CH_FIELD_W-1:0];
    assign unused_wbits = ^{wdata[DATA_W-1:VALID_BIT+1], wdata[VALID_BIT-1:CH_FIELD_W]};

    for (genvar n = 0; n < NUM_REQ; n++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[n] <= '0;
            end else if (wr_en && sel.hit && (int'(sel.idx) == n)) begin
                table_q[n] <= wr_route;
            end
        end
        assign vld_vec[n] = table_q[n].vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sel.hit ? pack_route(table_q[sel.idx]) : '0;
        end
    end

    // R9: an access that misses the decode leaves the valid flags untouched
    a_r9_miss_keeps_table: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sel.hit) |=> $stable(vld_vec));

    // R7: an all-zero write clears the addressed entry's valid flag
    a_r7_zero_unmaps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.hit && wdata == '0) |=> !vld_vec[$past(sel.idx)]);

    // R4: unused read bits are always zero
    a_r4_rdata_clean: assert property (@(posedge clk) disable iff (rst)
        (rdata[DATA_W-1:VALID_BIT+1] == '0) && (rdata[VALID_BIT-1:CH_FIELD_W] == '0));

endmodule

// File: rtl/reqmap_xbar.sv
module reqmap_xbar
    import reqmap_pkg::*;
#(
    parameter int NUM_REQ = 96,
    parameter int NUM_CH  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  route_t [NUM_REQ-1:0] table_q,
    input  logic [NUM_REQ-1:0]   req_in,
    output logic [NUM_CH-1:0]    ch_req_out
);
    logic [NUM_CH-1:0] ch_req_d;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam ch_num_t CH_ID = ch_num_t'(c);
        always_comb begin
            ch_req_d[c] = 1'b0;
            for (int n = 0; n < NUM_REQ; n++) begin
                ch_req_d[c] = ch_req_d[c] |
                    (req_in[n] & table_q[n].vld & (table_q[n].ch == CH_ID));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ch_req_out <= '0;
        else     ch_req_out <= ch_req_d;
    end

    // R5: a channel output can only rise from a request seen the cycle before
    a_r5_out_needs_request: assert property (@(posedge clk) disable iff (rst)
        (ch_req_out != '0) |-> ($past(req_in) != '0));

    // R1: the first cycle after reset shows no channel request
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ch_req_out == '0));

endmodule

// File: rtl/reqmap_router.sv
module reqmap_router
    import reqmap_pkg::*;
#(
    parameter int NUM_REQ = 96,
    parameter int NUM_CH  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [12:0]        addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_CH-1:0]  ch_req_out
);
    slot_sel_t            sel;
    route_t [NUM_REQ-1:0] table_q;

    initial begin
        a_cfg_sizes: assert (NUM_REQ <= 2 * BANK_WORDS && NUM_CH <= (1 << CH_FIELD_W));
    end

    reqmap_decode #(.NUM_REQ(NUM_REQ)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    reqmap_store #(.NUM_REQ(NUM_REQ)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .sel     (sel),
        .wdata   (wdata),
        .rdata   (rdata),
        .table_q (table_q)
    );

    reqmap_xbar #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_xbar (
        .clk        (clk),
        .rst        (rst),
        .table_q    (table_q),
        .req_in     (req_in),
        .ch_req_out (ch_req_out)
    );

    // R9: a read that misses the decode returns zero
    a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sel.hit) |=> (rdata == '0));

endmodule

// File: tb/reqmap_router_bench.sv
module reqmap_router_bench;
    localparam int NREQ = 96;
    localparam int NCH  = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [12:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NREQ-1:0] req_in = '0;
    logic [NCH-1:0]  ch_req_out;

    always #5 clk = ~clk;

    reqmap_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) u_reqmap_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_in(req_in), .ch_req_out(ch_req_out)
    );

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    mv[NREQ];
    int    mc[NREQ];

    function automatic logic [12:0] addr_of(int n);
        if (n < 64) return 13'(32'h100 + 4 * n);
        return 13'(32'h1100 + 4 * (n - 64));
    endfunction

    function automatic logic [31:0] model_out(logic [NREQ-1:0] v);
        logic [31:0] o = '0;
        for (int n = 0; n < NREQ; n++)
            if (v[n] && mv[n] && mc[n] < NCH) o[mc[n]] = 1'b1;
        return o;
    endfunction

    task automatic write_map(int n, logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; addr = addr_of(n); wdata = val;
        @(negedge clk);
        wr_en = 1'b0;
        mv[n] = val[7];
        mc[n] = int'(val[4:0]);
    endtask

    task automatic write_raw(logic [12:0] a, logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(logic [12:0] a, logic [31:0] exp, string tag);
        item_t it;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        it.is_read = 1'b1; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drive_req(logic [NREQ-1:0] v, string tag);
        item_t it;
        @(negedge clk);
        req_in = v;
        it.is_read = 1'b0; it.exp = model_out(v); it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    function automatic logic [NREQ-1:0] bit_at(int n);
        logic [NREQ-1:0] v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = it.is_read ? rdata : 32'(ch_req_out);
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < NREQ; n++) begin mv[n] = 0; mc[n] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        drive_req('1, "R1 all lines after reset");
        read_at(addr_of(0), 32'h0, "R1 entry 0 after reset");
        read_at(addr_of(70), 32'h0, "R1 entry 70 after reset");

        // R2 / R5: low window
        write_map(3, 32'h85);
        read_at(13'h10C, 32'h85, "R2 entry 3 readback");
        drive_req(bit_at(3), "R5 line 3 to ch 5");

        // R3 / R4: high window, garbage in unused bits
        write_map(70, 32'hFFFF_FF9F);
        read_at(13'h1118, 32'h9F, "R3 R4 entry 70 readback");
        drive_req(bit_at(70), "R5 line 70 to ch 31");

        // R6: valid clear
        write_map(10, 32'h05);
        read_at(addr_of(10), 32'h05, "R6 entry 10 readback");
        drive_req(bit_at(10), "R6 line 10 invalid");

        // R8: OR of two lines to one channel
        write_map(20, 32'h85);
        drive_req(bit_at(3) | bit_at(20), "R8 lines 3 and 20 to ch 5");
        drive_req(bit_at(20), "R8 line 20 alone");
        drive_req(bit_at(3) | bit_at(70), "R8 mixed channels");

        // R7: zero write unmaps
        write_map(3, 32'h0);
        read_at(addr_of(3), 32'h0, "R7 entry 3 cleared");
        drive_req(bit_at(3), "R7 line 3 unmapped");
        drive_req(bit_at(20), "R7 line 20 unaffected");

        // R9: misses
        write_raw(13'h0200, 32'h87);
        write_raw(13'(32'h1100 + 4 * 40), 32'h87);
        write_raw(13'h0111, 32'h81);
        read_at(13'h0200, 32'h0, "R9 read outside windows");
        read_at(13'(32'h1100 + 4 * 40), 32'h0, "R9 read beyond last line");
        read_at(addr_of(4), 32'h0, "R9 unaligned write ignored");
        drive_req(bit_at(4), "R9 line 4 stays unmapped");
        drive_req('1, "R9 table unchanged");

        // R10: remap
        write_map(70, 32'h82);
        drive_req(bit_at(70), "R10 line 70 moved to ch 2");

        // R3: top line
        write_map(95, 32'h80);
        read_at(13'h117C, 32'h80, "R3 entry 95 readback");
        drive_req(bit_at(95), "R3 line 95 to ch 0");
        drive_req('1, "R8 all lines final");

        drive_req('0, "R5 quiet");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule